// File: doc/BRIEF.md
# Peak-Level Driven Gain Stepping Controller

This block sets the gain of a programmable amplifier from a two-bit word produced by a level detector. On a periodic one-cycle evaluation strobe it reads the level word. If the signal is too large it lowers the gain by one step. If the signal is too small it raises the gain by one step. When the signal lies inside the target window it locks. The gain is an index from 0 to 7, and a fixed decode turns that index into the three switch-select lines of a capacitor bank. The decode is not binary: the ascending normalized gains are 1, 3, 4, 5, 6, 7, 8 and 10.

The first in-window reading freezes the gain for good. The lock also raises a converter enable, which joins the amplifier output to the converter, powers the converter and stops the gain loop. Only a synchronous reset ends the lock. After reset the index is back at step 0. The strobe period is chosen by the system to be longer than one heartbeat, so that the minor peaks of a beat do not cause gain changes.

The controller has two named states. The state SEEK moves gain. The state LOCKED holds it. It has these transitions:
- SEEK_STAY: SEEK stays in SEEK with no strobe, with a strobe and level 00 or 11, or with the illegal level 01.
- SEEK_TO_LOCKED: a strobe with level 10 moves SEEK to LOCKED.
- LOCKED_STAY: LOCKED stays in LOCKED on every input.
- RESET_TO_SEEK: reset moves either state to SEEK.

Top module: `gain_step_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller goes to SEEK. After that edge `gain_idx` is 0, `sw_sel` is 000, and `locked` and `conv_en` are both 0.
- R2: In SEEK, a strobe with level 11 (below window) raises `gain_idx` by exactly one at that clock edge.
- R3: In SEEK, a strobe with level 00 (above window) lowers `gain_idx` by exactly one at that clock edge.
- R4: The index saturates. Level 11 at index 7 leaves it at 7, and level 00 at index 0 leaves it at 0. It never wraps.
- R5: In SEEK, a strobe with level 10 (in window) sets `locked` at that edge and leaves `gain_idx` unchanged.
- R6: Once `locked` is 1, it stays 1 and `gain_idx` does not change, whatever the strobe and level inputs do, until reset.
- R7: When `eval_stb` is 0, neither `gain_idx` nor `locked` changes, whatever the level word is.
- R8: A strobe with the illegal level 01 changes neither `gain_idx` nor `locked`.
- R9: `sw_sel` = {G3,G2,G1} follows the index as follows: 0→000, 1→001, 2→010, 3→100, 4→011, 5→101, 6→110, 7→111.
- R10: `conv_en` is 1 exactly when the controller is locked. It rises only at the edge after a strobe that carried level 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eval_stb | input | 1 | One-cycle evaluation strobe |
| level | input | 2 | Level word: 00 above, 10 inside, 11 below, 01 illegal |
| gain_idx | output | 3 | Current gain step index |
| sw_sel | output | 3 | Capacitor-bank switch selects {G3,G2,G1} |
| locked | output | 1 | Gain frozen |
| conv_en | output | 1 | Converter path enable and loop disable |

## Verification
The assertions check on every cycle the step rules that relate one cycle to the next. These rules are the single-step rise and fall, saturation at both ends, holding without a strobe or with code 01, the permanent freeze after lock, and the condition under which the converter enable rises. The bench scenarios alone show the exact switch pattern for each of the eight steps. They also show full ramps up and down to the limits, and that reset clears a held lock and the loop can then lock again at step 0.

// File: rtl/gain_pkg.sv
package gain_pkg;
    localparam int IDX_W = 3;
    localparam int SW_W  = 3;

    localparam logic [1:0] LVL_ABOVE  = 2'b00;
    localparam logic [1:0] LVL_INSIDE = 2'b10;
    localparam logic [1:0] LVL_BELOW  = 2'b11;

    typedef enum logic {
        ST_SEEK   = 1'b0,
        ST_LOCKED = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/gain_step_fsm.sv
module gain_step_fsm
    import gain_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       eval_stb,
    input  logic [1:0] level,
    output logic       step_up,
    output logic       step_down,
    output logic       locked,
    output logic       conv_en
);
    ctrl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEEK;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK:   if (eval_stb && level == LVL_INSIDE) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_SEEK;
        endcase
    end

    // outputs
    always_comb begin
        step_up   = 1'b0;
        step_down = 1'b0;
        locked    = 1'b0;
        conv_en   = 1'b0;
        unique case (state_q)
            ST_SEEK: begin
                if (eval_stb) begin
                    step_up   = (level == LVL_BELOW);
                    step_down = (level == LVL_ABOVE);
                end
            end
            ST_LOCKED: begin
                locked  = 1'b1;
                conv_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gain_step_index.sv
module gain_step_index #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_down,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] IDX_TOP = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)                              idx <= '0;
        else if (step_up   && idx != IDX_TOP) idx <= idx + IDX_ONE;
        else if (step_down && idx != '0)      idx <= idx - IDX_ONE;
    end
endmodule

// File: rtl/gain_switch_decode.sv
module gain_switch_decode
    import gain_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [SW_W-1:0]  sw_sel
);
    always_comb begin
        unique case (idx)
            3'd0: sw_sel = 3'b000;
            3'd1: sw_sel = 3'b001;
            3'd2: sw_sel = 3'b010;
            3'd3: sw_sel = 3'b100;
            3'd4: sw_sel = 3'b011;
            3'd5: sw_sel = 3'b101;
            3'd6: sw_sel = 3'b110;
            default: sw_sel = 3'b111;
        endcase
    end
endmodule

// File: rtl/gain_step_ctrl.sv
module gain_step_ctrl
    import gain_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eval_stb,
    input  logic [1:0]       level,
    output logic [IDX_W-1:0] gain_idx,
    output logic [SW_W-1:0]  sw_sel,
    output logic             locked,
    output logic             conv_en
);
    logic step_up, step_down;

    gain_step_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .eval_stb  (eval_stb),
        .level     (level),
        .step_up   (step_up),
        .step_down (step_down),
        .locked    (locked),
        .conv_en   (conv_en)
    );

    gain_step_index #(.IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst       (rst),
        .step_up   (step_up),
        .step_down (step_down),
        .idx       (gain_idx)
    );

    gain_switch_decode u_dec (
        .idx    (gain_idx),
        .sw_sel (sw_sel)
    );
endmodule

// File: rtl/gain_step_chk.sv
module gain_step_chk (
    input logic       clk,
    input logic       rst,
    input logic       eval_stb,
    input logic [1:0] level,
    input logic [2:0] gain_idx,
    input logic       locked,
    input logic       conv_en
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (gain_idx == 3'd0 && !locked && !conv_en)); // R1
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst) (eval_stb && level == 2'b11 && !locked && gain_idx != 3'd7) |=> gain_idx == $past(gain_idx) + 3'd1); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst) (eval_stb && level == 2'b00 && !locked && gain_idx != 3'd0) |=> gain_idx == $past(gain_idx) - 3'd1); // R3
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst) (eval_stb && level == 2'b11 && gain_idx == 3'd7) |=> gain_idx == 3'd7); // R4
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst) (eval_stb && level == 2'b00 && gain_idx == 3'd0) |=> gain_idx == 3'd0); // R4
    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst) (eval_stb && level == 2'b10) |=> (locked && $stable(gain_idx))); // R5
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst) locked |=> (locked && $stable(gain_idx))); // R6
    AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst) !eval_stb |=> ($stable(gain_idx) && $stable(locked))); // R7
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst) (eval_stb && level == 2'b01) |=> ($stable(gain_idx) && $stable(locked))); // R8
    AST_ENABLE_RISE: assert property (@(posedge clk) disable iff (rst) $rose(conv_en) |-> ($past(eval_stb) && $past(level) == 2'b10 && locked)); // R10
endmodule

bind gain_step_ctrl gain_step_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .eval_stb (eval_stb),
    .level    (level),
    .gain_idx (gain_idx),
    .locked   (locked),
    .conv_en  (conv_en)
);

// File: tb/gain_step_ctrl_test.sv
module gain_step_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       eval_stb = 1'b0;
    logic [1:0] level = 2'b01;
    logic [2:0] gain_idx;
    logic [2:0] sw_sel;
    logic       locked;
    logic       conv_en;

    gain_step_ctrl uut (
        .clk(clk), .rst(rst), .eval_stb(eval_stb), .level(level),
        .gain_idx(gain_idx), .sw_sel(sw_sel), .locked(locked), .conv_en(conv_en)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [2:0] idx;
        logic       lk;
        string      tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    logic [2:0] m_idx = 3'd0;
    logic       m_lk  = 1'b0;
    bit         done  = 1'b0;

    // switch pattern from R9
    function automatic logic [2:0] sw_of(input logic [2:0] i);
        case (i)
            3'd0: return 3'b000;
            3'd1: return 3'b001;
            3'd2: return 3'b010;
            3'd3: return 3'b100;
            3'd4: return 3'b011;
            3'd5: return 3'b101;
            3'd6: return 3'b110;
            default: return 3'b111;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; eval_stb = 1'b0;
        @(posedge clk);
        m_idx = 3'd0; m_lk = 1'b0;
        q.push_back('{idx: m_idx, lk: m_lk, tag: "R1"});
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive(input logic stb, input logic [1:0] lvl, input string tag);
        @(negedge clk);
        eval_stb = stb; level = lvl;
        @(posedge clk);
        if (stb && !m_lk) begin
            case (lvl)
                2'b11: if (m_idx != 3'd7) m_idx = m_idx + 3'd1;
                2'b00: if (m_idx != 3'd0) m_idx = m_idx - 3'd1;
                2'b10: m_lk = 1'b1;
                default: ;
            endcase
        end
        q.push_back('{idx: m_idx, lk: m_lk, tag: tag});
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                total += 4;
                if (gain_idx !== e.idx) begin
                    bad++; $display("FAIL %s gain_idx act=%0d exp=%0d", e.tag, gain_idx, e.idx);
                end
                if (sw_sel !== sw_of(e.idx)) begin
                    bad++; $display("FAIL R9 (%s) sw_sel act=%b exp=%b", e.tag, sw_sel, sw_of(e.idx));
                end
                if (locked !== e.lk) begin
                    bad++; $display("FAIL %s locked act=%b exp=%b", e.tag, locked, e.lk);
                end
                if (conv_en !== e.lk) begin
                    bad++; $display("FAIL R10 (%s) conv_en act=%b exp=%b", e.tag, conv_en, e.lk);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();                                        // R1
        drive(1'b0, 2'b11, "R7");                          // no strobe, below
        drive(1'b0, 2'b10, "R7");                          // no strobe, inside: no lock
        for (int i = 0; i < 7; i++) drive(1'b1, 2'b11, "R2");
        drive(1'b1, 2'b11, "R4");                          // top saturation
        drive(1'b1, 2'b11, "R4");
        drive(1'b1, 2'b01, "R8");                          // illegal at 7
        for (int i = 0; i < 7; i++) drive(1'b1, 2'b00, "R3");
        drive(1'b1, 2'b00, "R4");                          // bottom saturation
        drive(1'b1, 2'b01, "R8");
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 2'b11, "R2");
            drive(1'b0, 2'b00, "R7");
        end
        drive(1'b1, 2'b10, "R5");                          // lock at step 3
        drive(1'b1, 2'b11, "R6");
        drive(1'b1, 2'b00, "R6");
        drive(1'b1, 2'b10, "R6");
        drive(1'b0, 2'b11, "R6");
        do_reset();                                        // R1 clears lock
        drive(1'b1, 2'b10, "R5");                          // lock at step 0
        drive(1'b1, 2'b11, "R6");
        do_reset();
        drive(1'b1, 2'b11, "R2");
        drive(1'b1, 2'b11, "R2");
        drive(1'b1, 2'b11, "R2");
        drive(1'b1, 2'b11, "R2");
        drive(1'b1, 2'b00, "R3");
        drive(1'b1, 2'b10, "R5");                          // lock at step 3 again
        drive(1'b1, 2'b01, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule